// File: doc/BRIEF.md
# Context-Tagged Virtual Write-Through Cache

This block is a direct-mapped data cache that sits in front of a simple memory port. Both the index and the tag come from the virtual address, so the cache needs no translation in front of it. A line is usable only if its stored tag matches and the address-space context it was filled under equals the context of the current access. The CPU presents the access together with its context, its privilege mode and the writable and privileged bits of the page mapping. The cache stores those page bits when it fills a line and checks them on every later hit. A hit that breaks them is reported as a protection fault and changes nothing.

Writes always go through to memory. A write hit also patches the cached word under its byte enables. A write miss leaves the cache untouched. A read miss fetches the whole 16-byte line as a four-beat burst. A separate port reads and writes raw tag words so that software can inspect lines, plant them or invalidate them. A control bit switches the cache on. When it is off, every access goes straight to memory as a single beat.

The CPU request, CPU response, memory request and raw tag port are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. A source holds its valid and payload until that edge. The cache raises `req_ready` only when it is idle. It then holds `rsp_valid` and the response fields unchanged for as long as `rsp_ready` stays low, so only one access is in flight at a time. A raw tag access that is pending while the cache is idle takes precedence over a CPU request. Memory read beats on `mem_rvalid` are always accepted.

Top module: `vc_cache`

## Requirements
- R1: The line index is address bits 15:4, the word within the line is bits 3:2 and the tag ID is bits 29:16. Addresses that differ only in bits 31:30 hit the same cached line.
- R2: An access hits only when the cache is on, the line's valid bit is set, its stored tag ID equals address bits 29:16 and its stored context equals `req_ctx`. A different tag or a different context is a miss.
- R3: A read miss with the cache on issues one memory read with `mem_req_burst`=1 at the line address with bits 3:0 cleared. It takes four beats in word order and answers with the requested word and `rsp_hit`=0. It installs the line with the tag ID, the context, `req_pg_w`, `req_pg_p` and valid=1.
- R4: Every write that does not fault issues exactly one single-beat memory write of `req_wdata` and `req_be` at the word address. On a hit, the bytes of the cached word that `req_be` selects are replaced, so a later read hit returns the merged word.
- R5: A write miss answers `rsp_hit`=0 and allocates no line, so the next read of that address misses and fetches from memory.
- R6: A write that hits a line whose stored writable bit is 0 answers `rsp_hit`=1, `rsp_fault`=1 and `rsp_rdata`=0. It issues no memory write and leaves the cached data unchanged.
- R7: An access with `req_user`=1 that hits a line whose stored privileged bit is 1 faults in the same way. The same access in supervisor mode does not fault.
- R8: A raw tag word has the context in bits 24:22, the writable bit in bit 21, the privileged bit in bit 20, the valid bit in bit 19 and the tag ID in bits 15:2. All other bits read as 0 no matter what was written. The read result appears on `tag_rdata` one cycle after the read transfer.
- R9: A raw tag write takes effect on the next lookup. Writing valid=0 turns the line into a miss. Writing a valid tag makes a matching access hit with the written permission bits.
- R10: With the cache off, a read issues a single-beat memory read (`mem_req_burst`=0), answers `rsp_hit`=0 with the memory word, and changes no tag.
- R11: After reset, the cache is off, every line is invalid and `req_ready` is 1.
- R12: `rsp_valid`, `rsp_rdata`, `rsp_hit` and `rsp_fault` stay steady while `rsp_ready` is low. `req_ready` is 0 while a response is pending. The memory request payload stays steady until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the enable bit |
| cfg_on_in | input | 1 | Value loaded into the enable bit |
| cache_on | output | 1 | Current enable bit |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request accepted |
| req_addr | input | 32 | Virtual byte address, word aligned |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| req_ctx | input | 3 | Current context number |
| req_user | input | 1 | 1 = user mode |
| req_pg_w | input | 1 | Page writable bit, stored on fill |
| req_pg_p | input | 1 | Page privileged bit, stored on fill |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Read data (0 on writes and faults) |
| rsp_hit | output | 1 | Access hit a usable line |
| rsp_fault | output | 1 | Protection fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 32 | Memory address |
| mem_req_write | output | 1 | 1 = write |
| mem_req_burst | output | 1 | 1 = four-beat line read |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_be | output | 4 | Memory write byte enables |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| tag_valid | input | 1 | Raw tag access valid |
| tag_ready | output | 1 | Raw tag access accepted |
| tag_we | input | 1 | 1 = raw write, 0 = raw read |
| tag_idx | input | 12 | Line index of the raw access |
| tag_wdata | input | 32 | Raw tag word to write |
| tag_rdata | output | 32 | Raw tag word read |

## Verification
The cases hardest to reach from the ports are the protection faults and the context misses. Each needs a line already resident with particular stored page bits or a particular context, and the page bits given with a request matter only on a fill. The stimulus table therefore first misses on an address with the wanted page bits so the line is filled with them, and then touches the same line again in another mode, with a write, or under a different context. The directed tests also plant and invalidate lines through the raw tag port, so a fault or miss can be produced with no fill at all. Because the bench's memory content depends on the full address, a hit through an alias that differs only in bits 31:30 is shown by its returned data.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int VA_W    = 32;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;
  localparam int OFF_W   = 4;
  localparam int IDX_W   = 12;
  localparam int TID_W   = 14;
  localparam int CTX_W   = 3;
  localparam int WSEL_W  = OFF_W - 2;
  localparam int BEATS   = 1 << WSEL_W;
  localparam int LINE_W  = BEATS * WORD_W;
  localparam int LINES   = 1 << IDX_W;
  localparam int TID_LSB = OFF_W + IDX_W;

  // Raw tag word field positions (software decodes these)
  localparam int RT_TID_LSB = 2;
  localparam int RT_V       = 19;
  localparam int RT_P       = 20;
  localparam int RT_W       = 21;
  localparam int RT_CTX_LSB = 22;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             wr_ok;
    logic             priv;
    logic [TID_W-1:0] tid;
  } tag_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_MREQ, ST_FILL, ST_RESP
  } st_t;

  typedef struct packed {
    logic [VA_W-1:0]   addr;
    logic [WORD_W-1:0] wdata;
    logic [BE_W-1:0]   be;
    logic              write;
    logic [CTX_W-1:0]  ctx;
    logic              user;
    logic              pg_w;
    logic              pg_p;
    logic              en;
  } req_t;

  function automatic logic [WORD_W-1:0] tag_to_raw(tag_t t, logic v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RT_CTX_LSB +: CTX_W] = t.ctx;
    w[RT_W]                = t.wr_ok;
    w[RT_P]                = t.priv;
    w[RT_V]                = v;
    w[RT_TID_LSB +: TID_W] = t.tid;
    return w;
  endfunction

  function automatic tag_t raw_to_tag(logic [WORD_W-1:0] w);
    tag_t t;
    t.ctx   = w[RT_CTX_LSB +: CTX_W];
    t.wr_ok = w[RT_W];
    t.priv  = w[RT_P];
    t.tid   = w[RT_TID_LSB +: TID_W];
    return t;
  endfunction
endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store
  import vc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output tag_t              lk_tag,
  output logic              lk_valid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tag_t              wr_tag,
  input  logic              wr_valid,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINES-1:0] vbits;
  tag_t             tags [LINES];

  // valid bits live in flops so that reset clears every line at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vbits <= '0;
    else if (wr_en) vbits[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word <= '0;
    else if (rd_en) rd_word <= tag_to_raw(tags[rd_idx], vbits[rd_idx]);
  end

  assign lk_tag   = tags[lk_idx];
  assign lk_valid = vbits[lk_idx];
endmodule

// File: rtl/vc_data_store.sv
module vc_data_store
  import vc_pkg::*;
(
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              line_we,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              word_we,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [BE_W-1:0]   wr_be
);
  logic [LINE_W-1:0] lines [LINES];
  logic [LINE_W-1:0] cur;
  logic [LINE_W-1:0] merged;

  assign cur     = lines[idx];
  assign rd_line = cur;

  for (genvar w = 0; w < BEATS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign merged[w*WORD_W + b*8 +: 8] =
        (wr_sel == WSEL_W'(w) && wr_be[b]) ? wr_word[b*8 +: 8]
                                           : cur[w*WORD_W + b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (line_we)      lines[idx] <= wr_line;
    else if (word_we) lines[idx] <= merged;
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_on,
  input  logic              tag_busy,
  output logic              idle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_user,
  input  logic              req_pg_w,
  input  logic              req_pg_p,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic              mem_req_write,
  output logic              mem_req_burst,
  output logic [WORD_W-1:0] mem_req_wdata,
  output logic [BE_W-1:0]   mem_req_be,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  tag_t              lk_tag,
  input  logic              lk_valid,
  input  logic [LINE_W-1:0] lk_line,
  output logic              fill_we,
  output tag_t              fill_tag,
  output logic [LINE_W-1:0] fill_line,
  output logic              dw_word_we,
  output logic [WSEL_W-1:0] dw_sel,
  output logic [WORD_W-1:0] dw_word,
  output logic [BE_W-1:0]   dw_be
);
  st_t               st;
  req_t              r;
  logic [WSEL_W-1:0] beat;
  logic [WORD_W-1:0] lbuf [BEATS];

  logic match, hit, fault, burst, last, capture;
  logic [WSEL_W-1:0] sel;

  assign lk_idx = r.addr[OFF_W +: IDX_W];
  assign sel    = r.addr[2 +: WSEL_W];
  assign match  = lk_valid && (lk_tag.tid == r.addr[TID_LSB +: TID_W]) && (lk_tag.ctx == r.ctx);
  assign hit    = r.en && match;
  assign fault  = hit && ((r.write && !lk_tag.wr_ok) || (r.user && lk_tag.priv));
  assign burst  = r.en && !r.write;
  assign last   = burst ? (beat == WSEL_W'(BEATS-1)) : 1'b1;
  assign capture = burst ? (beat == sel) : 1'b1;

  assign idle      = (st == ST_IDLE);
  assign req_ready = idle && !tag_busy;
  assign rsp_valid = (st == ST_RESP);

  assign mem_req_valid = (st == ST_MREQ);
  assign mem_req_write = r.write;
  assign mem_req_burst = burst;
  assign mem_req_wdata = r.wdata;
  assign mem_req_be    = r.write ? r.be : '0;
  assign mem_req_addr  = burst ? {r.addr[VA_W-1:OFF_W], {OFF_W{1'b0}}}
                               : {r.addr[VA_W-1:2], 2'b00};

  // whole-line image with the arriving beat spliced in
  for (genvar w = 0; w < BEATS; w++) begin : g_fill
    assign fill_line[w*WORD_W +: WORD_W] = (beat == WSEL_W'(w)) ? mem_rdata : lbuf[w];
  end

  assign fill_we        = (st == ST_FILL) && mem_rvalid && last && burst;
  assign fill_tag.ctx   = r.ctx;
  assign fill_tag.wr_ok = r.pg_w;
  assign fill_tag.priv  = r.pg_p;
  assign fill_tag.tid   = r.addr[TID_LSB +: TID_W];

  assign dw_word_we = (st == ST_LOOK) && hit && r.write && !fault;
  assign dw_sel     = sel;
  assign dw_word    = r.wdata;
  assign dw_be      = r.be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      r         <= '0;
      beat      <= '0;
      rsp_rdata <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          r.addr  <= req_addr;
          r.wdata <= req_wdata;
          r.be    <= req_be;
          r.write <= req_write;
          r.ctx   <= req_ctx;
          r.user  <= req_user;
          r.pg_w  <= req_pg_w;
          r.pg_p  <= req_pg_p;
          r.en    <= cache_on;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          rsp_hit   <= hit;
          rsp_fault <= fault;
          rsp_rdata <= '0;
          if (fault) begin
            st <= ST_RESP;
          end else if (hit && !r.write) begin
            rsp_rdata <= lk_line[sel*WORD_W +: WORD_W];
            st        <= ST_RESP;
          end else begin
            st <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) begin
          beat <= '0;
          st   <= r.write ? ST_RESP : ST_FILL;
        end
        ST_FILL: if (mem_rvalid) begin
          if (capture) rsp_rdata <= mem_rdata;
          beat <= beat + 1'b1;
          if (last) st <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_FILL && mem_rvalid) lbuf[beat] <= mem_rdata;
  end
endmodule

// File: rtl/vc_cache.sv
module vc_cache
  import vc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_on_in,
  output logic              cache_on,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_user,
  input  logic              req_pg_w,
  input  logic              req_pg_p,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic              mem_req_write,
  output logic              mem_req_burst,
  output logic [WORD_W-1:0] mem_req_wdata,
  output logic [BE_W-1:0]   mem_req_be,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              tag_valid,
  output logic              tag_ready,
  input  logic              tag_we,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [WORD_W-1:0] tag_wdata,
  output logic [WORD_W-1:0] tag_rdata
);
  logic              idle;
  logic [IDX_W-1:0]  lk_idx;
  tag_t              lk_tag;
  logic              lk_valid;
  logic [LINE_W-1:0] lk_line;
  logic              fill_we;
  tag_t              fill_tag;
  logic [LINE_W-1:0] fill_line;
  logic              dw_word_we;
  logic [WSEL_W-1:0] dw_sel;
  logic [WORD_W-1:0] dw_word;
  logic [BE_W-1:0]   dw_be;
  logic              raw_wr, raw_rd;
  logic              ts_wr_en, ts_wr_valid;
  logic [IDX_W-1:0]  ts_wr_idx;
  tag_t              ts_wr_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cache_on <= 1'b0;
    else if (cfg_wr) cache_on <= cfg_on_in;
  end

  assign tag_ready = idle;
  assign raw_wr    = tag_valid && tag_ready && tag_we;
  assign raw_rd    = tag_valid && tag_ready && !tag_we;

  // raw writes only happen while idle, so they never meet a fill write
  assign ts_wr_en    = raw_wr || fill_we;
  assign ts_wr_idx   = raw_wr ? tag_idx : lk_idx;
  assign ts_wr_tag   = raw_wr ? raw_to_tag(tag_wdata) : fill_tag;
  assign ts_wr_valid = raw_wr ? tag_wdata[RT_V] : 1'b1;

  vc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_on(cache_on), .tag_busy(tag_valid), .idle(idle),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .req_be(req_be), .req_ctx(req_ctx), .req_user(req_user),
    .req_pg_w(req_pg_w), .req_pg_p(req_pg_p),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_write(mem_req_write), .mem_req_burst(mem_req_burst), .mem_req_wdata(mem_req_wdata),
    .mem_req_be(mem_req_be), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_line(lk_line),
    .fill_we(fill_we), .fill_tag(fill_tag), .fill_line(fill_line),
    .dw_word_we(dw_word_we), .dw_sel(dw_sel), .dw_word(dw_word), .dw_be(dw_be)
  );

  vc_tag_store u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid),
    .wr_en(ts_wr_en), .wr_idx(ts_wr_idx), .wr_tag(ts_wr_tag), .wr_valid(ts_wr_valid),
    .rd_en(raw_rd), .rd_idx(tag_idx), .rd_word(tag_rdata)
  );

  vc_data_store u_data (
    .clk(clk), .idx(lk_idx), .rd_line(lk_line),
    .line_we(fill_we), .wr_line(fill_line),
    .word_we(dw_word_we), .wr_sel(dw_sel), .wr_word(dw_word), .wr_be(dw_be)
  );
endmodule

// File: rtl/vc_cache_checker.sv
module vc_cache_checker
  import vc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [VA_W-1:0]   mem_req_addr,
  input logic              mem_req_write,
  input logic              mem_req_burst,
  input logic [WORD_W-1:0] tag_rdata
);
  localparam logic [WORD_W-1:0] RAW_MASK =
      (WORD_W'((1 << CTX_W) - 1) << RT_CTX_LSB) | (WORD_W'(1) << RT_W) |
      (WORD_W'(1) << RT_P) | (WORD_W'(1) << RT_V) |
      (WORD_W'((1 << TID_W) - 1) << RT_TID_LSB);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit) && $stable(rsp_fault));

  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  a_r3_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_burst |-> mem_req_addr[OFF_W-1:0] == '0 && !mem_req_write);

  a_r7_fault_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_hit && rsp_rdata == '0);

  a_r8_mbz_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_rdata & ~RAW_MASK) == '0);
endmodule

bind vc_cache vc_cache_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_req_write(mem_req_write), .mem_req_burst(mem_req_burst), .tag_rdata(tag_rdata)
);

// File: tb/vc_cache_tb.sv
module vc_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_wr = 0, cfg_on_in = 0, cache_on;
  logic        req_valid = 0, req_ready, req_write = 0, req_user = 0, req_pg_w = 0, req_pg_p = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic [2:0]  req_ctx = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_hit, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready = 0, mem_req_write, mem_req_burst;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic        tag_valid = 0, tag_ready, tag_we = 0;
  logic [11:0] tag_idx = 0;
  logic [31:0] tag_wdata = 0, tag_rdata;

  vc_cache u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int n_mwr = 0, n_burst = 0, n_single = 0;
  logic [31:0] mem_m [int unsigned];
  logic [31:0] ref_base [int unsigned];

  function automatic logic [31:0] defval(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h2468_ACE0;
  endfunction

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return defval(a);
  endfunction

  function automatic string rname(int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model: accepts requests after a varying delay, returns read beats in order
  initial begin : mem_side
    int dly;
    dly = 0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a, wd;
        logic w, bu;
        logic [3:0] be;
        repeat (dly) @(negedge clk);
        dly = (dly + 1) % 3;
        a = mem_req_addr; w = mem_req_write; bu = mem_req_burst; wd = mem_req_wdata; be = mem_req_be;
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        if (w) begin
          logic [31:0] v;
          v = mem_rd(a);
          for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = wd[b*8 +: 8];
          mem_m[a] = v;
          n_mwr++;
        end else begin
          if (bu) n_burst++; else n_single++;
          for (int b = 0; b < (bu ? 4 : 1); b++) begin
            mem_rvalid = 1;
            mem_rdata  = mem_rd(a + 32'(4 * b));
            @(negedge clk);
          end
          mem_rvalid = 0;
        end
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        input logic [3:0] be, input logic [2:0] cx, input logic us,
                        input logic pw, input logic pp, input int hold,
                        output logic [31:0] rd, output logic h, output logic f);
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = wd; req_be = be; req_ctx = cx;
    req_user = us; req_pg_w = pw; req_pg_p = pp; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; h = rsp_hit; f = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready, "R12", "response held under back-pressure", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_rdata == rd && rsp_hit == h && rsp_fault == f, "R12", "response stable", rsp_rdata, rd);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic tag_op(input logic we, input logic [11:0] idx, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    tag_valid = 1; tag_we = we; tag_idx = idx; tag_wdata = wd;
    while (!tag_ready) @(negedge clk);
    @(negedge clk);
    tag_valid = 0; tag_we = 0;
    rd = tag_rdata;
  endtask

  task automatic set_on(input logic v);
    @(negedge clk);
    cfg_wr = 1; cfg_on_in = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [2:0]  cx;
    logic        us, pw, pp;
    logic        exp_hit, exp_fault;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_2340, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},
    '{32'h0001_2348, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
    '{32'hC001_2344, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
    '{32'h0001_2340, 1'b0, 32'h0,         4'h0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{32'h0001_2340, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{32'h0001_2344, 1'b1, 32'hAAAA_BBBB, 4'h3, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    '{32'h0001_2344, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    '{32'h0002_5000, 1'b1, 32'h1234_5678, 4'hF, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
    '{32'h0002_5000, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
    '{32'h0003_7000, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{32'h0003_7000, 1'b1, 32'hDEAD_BEEF, 4'hF, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},
    '{32'h0003_7000, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},
    '{32'h0004_8010, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},
    '{32'h0004_8010, 1'b0, 32'h0,         4'h0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7},
    '{32'h0004_8014, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7},
    '{32'h0005_2340, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{32'h0001_2340, 1'b0, 32'h0,         4'h0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2}
  };

  task automatic run_all();
    logic [31:0] rd, traw;
    logic h, f;
    int w0, b0, s0;

    // reset state (R11)
    @(negedge clk);
    chk(cache_on == 1'b0, "R11", "cache off after reset", {31'd0, cache_on}, 32'd0);
    chk(req_ready == 1'b1, "R11", "ready after reset", {31'd0, req_ready}, 32'd1);
    tag_op(1'b0, 12'h234, 32'h0, traw);
    chk(traw[19] == 1'b0, "R11", "line invalid after reset", traw, 32'h0);

    // disabled: bypass (R10)
    b0 = n_burst; s0 = n_single;
    access(32'h0001_2340, 0, 0, 0, 3'd1, 0, 1, 0, 0, rd, h, f);
    chk(!h && rd == mem_rd(32'h0001_2340), "R10", "bypass read data", rd, mem_rd(32'h0001_2340));
    chk(n_burst == b0 && n_single == s0 + 1, "R10", "single-beat read", 32'(n_single - s0), 32'd1);
    access(32'h0001_2340, 0, 0, 0, 3'd1, 0, 1, 0, 0, rd, h, f);
    chk(h == 1'b0, "R10", "no fill while off", {31'd0, h}, 32'd0);

    set_on(1'b1);
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] exp_d;
      int idx;
      v = VEC[i];
      idx = int'(v.addr[15:4]);
      w0 = n_mwr; b0 = n_burst;
      if (v.exp_hit) exp_d = mem_rd(ref_base[idx] | {28'd0, v.addr[3:0]});
      else           exp_d = mem_rd(v.addr);
      access(v.addr, v.wr, v.wd, v.be, v.cx, v.us, v.pw, v.pp, (i == 6) ? 4 : 0, rd, h, f);
      chk(h == v.exp_hit, rname(int'(v.rq)), $sformatf("vector %0d hit", i), {31'd0, h}, {31'd0, v.exp_hit});
      chk(f == v.exp_fault, rname(int'(v.rq)), $sformatf("vector %0d fault", i), {31'd0, f}, {31'd0, v.exp_fault});
      if (!v.wr && !v.exp_fault)
        chk(rd == exp_d, rname(int'(v.rq)), $sformatf("vector %0d data", i), rd, exp_d);
      if (v.exp_fault)
        chk(rd == 32'h0, rname(int'(v.rq)), $sformatf("vector %0d fault data", i), rd, 32'h0);
      chk(n_mwr - w0 == ((v.wr && !v.exp_fault) ? 1 : 0), rname(int'(v.rq)),
          $sformatf("vector %0d memory writes", i), 32'(n_mwr - w0), {31'd0, v.wr && !v.exp_fault});
      chk(n_burst - b0 == ((!v.wr && !v.exp_hit) ? 1 : 0), rname(int'(v.rq)),
          $sformatf("vector %0d line fetches", i), 32'(n_burst - b0), {31'd0, !v.wr && !v.exp_hit});
      if (!v.wr && !v.exp_hit) ref_base[idx] = {v.addr[31:4], 4'h0};
    end

    // raw tag layout (R8)
    tag_op(1'b0, 12'h234, 32'h0, traw);
    chk(traw == 32'h0068_0004, "R8", "raw tag of filled line", traw, 32'h0068_0004);
    tag_op(1'b1, 12'h600, 32'hFFFF_FFFF, traw);
    tag_op(1'b0, 12'h600, 32'h0, traw);
    chk(traw == 32'h01F8_FFFC, "R8", "reserved bits read zero", traw, 32'h01F8_FFFC);

    // raw tag writes steer lookups (R9)
    tag_op(1'b1, 12'h234, 32'h0, traw);
    b0 = n_burst;
    access(32'h0001_2340, 0, 0, 0, 3'd1, 0, 1, 0, 0, rd, h, f);
    chk(!h && n_burst == b0 + 1, "R9", "invalidated line misses", {31'd0, h}, 32'd0);
    tag_op(1'b1, 12'h900, 32'h0048_001C, traw);
    w0 = n_mwr;
    access(32'h0007_9000, 1, 32'h5555_5555, 4'hF, 3'd1, 0, 1, 0, 0, rd, h, f);
    chk(h && f && n_mwr == w0, "R9", "planted read-only line faults", {30'd0, h, f}, 32'd3);

    // disabled again: faulted write never reached memory (R6, R10)
    set_on(1'b0);
    access(32'h0003_7000, 0, 0, 0, 3'd1, 0, 1, 0, 0, rd, h, f);
    chk(!h && rd == defval(32'h0003_7000), "R6", "memory untouched by faulted write", rd, defval(32'h0003_7000));
    tag_op(1'b0, 12'h700, 32'h0, traw);
    chk(traw[19] == 1'b1, "R10", "bypass leaves tags alone", traw, 32'h0048_0000 | traw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog expired: actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule